// File: doc/BRIEF.md
# Partitioned Pixel ALU

This block is a SIMD pixel unit that treats two 64-bit operands, A and B, as packed groups of bytes, 16-bit lanes or 32-bit lanes. A 5-bit opcode picks the operation. The operations are:

- byte interleave of the low halves of the operands;
- widening of four bytes into 16-bit fixed-point lanes;
- lane-wise add and subtract, on full 64-bit data or on narrow 32-bit data;
- unsigned lane compares that return a packed bit mask.

Lane 0 is always the least significant lane.

The block has one register stage. An operation is presented together with a strobe. The result and a valid flag appear on the next clock edge. The result then holds until the next strobe. Opcode values that name no operation produce an all-zero result.

Top module: `pix_simd_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `res_vld` is 0 and `res` is all zeros until the first strobe.
- R2: A strobe on `in_vld` produces `res_vld` = 1 and the new `res` one clock edge later. A cycle without a strobe drives `res_vld` to 0 and leaves `res` unchanged.
- R3: Opcode 0 (merge) gives output bytes 7 down to 0 as A3, B3, A2, B2, A1, B1, A0, B0, where An and Bn are byte n of the operand's low 32 bits.
- R4: Opcode 1 (expand) turns byte i of A's low 32 bits into 16-bit lane i as the zero-extended byte shifted left by 4. B is not used.
- R5: Opcodes 2 (four 16-bit lanes) and 3 (two 32-bit lanes) give B + A per lane, modulo the lane width, with no carry crossing a lane boundary.
- R6: Opcodes 4 (16-bit lanes) and 5 (32-bit lanes) give B − A per lane, modulo the lane width, with no borrow crossing a lane boundary.
- R7: The narrow forms work on the low 32 bits only and force result bits 63:32 to zero. They are opcode 6 (add, two 16-bit lanes), 7 (add, one 32-bit lane), 8 (subtract, two 16-bit lanes) and 9 (subtract, one 32-bit lane).
- R8: The compare opcodes evaluate "A lane relation B lane" on unsigned lane values. The relations are greater-than (16 for 16-bit lanes, 17 for 32-bit lanes), equal (18, 19), less-or-equal (20, 21) and not-equal (22, 23).
- R9: A compare result places the outcome of lane i in bit i. In 16-bit mode the mask is bits 3:0. In 32-bit mode the mask is bits 1:0. All other result bits are zero.
- R10: Opcodes 10 to 15 and 24 to 31 produce an all-zero result, with `res_vld` still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Operation strobe |
| op | input | 5 | Operation code |
| opa | input | 64 | Operand A |
| opb | input | 64 | Operand B |
| res_vld | output | 1 | Result valid, one cycle after the strobe |
| res | output | 64 | Registered result |

## Verification
All state apart from reset synchronisation sits in the result register and its valid flag. A fault therefore shows at the ports on the edge right after the strobe.

A fault in the lane datapath appears as a wrong value in one lane, or as a carry leaking into the neighbouring lane. A fault in the register enable appears as a result that changes on an idle cycle. A fault in the mask placement appears as nonzero bits above the mask.

Carry and borrow boundaries are driven deliberately, and each lane carries a distinct value, so lane swaps and lane leaks cannot cancel out.

// File: rtl/pix_pkg.sv
package pix_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_MERGE  = 5'd0,
    OP_EXPAND = 5'd1,
    OP_ADD16  = 5'd2,
    OP_ADD32  = 5'd3,
    OP_SUB16  = 5'd4,
    OP_SUB32  = 5'd5,
    OP_ADD16N = 5'd6,
    OP_ADD32N = 5'd7,
    OP_SUB16N = 5'd8,
    OP_SUB32N = 5'd9,
    OP_GT16   = 5'd16,
    OP_GT32   = 5'd17,
    OP_EQ16   = 5'd18,
    OP_EQ32   = 5'd19,
    OP_LE16   = 5'd20,
    OP_LE32   = 5'd21,
    OP_NE16   = 5'd22,
    OP_NE32   = 5'd23
  } pix_op_e;

  // relation code taken from op[2:1] for compare opcodes
  typedef enum logic [1:0] {
    REL_GT = 2'd0,
    REL_EQ = 2'd1,
    REL_LE = 2'd2,
    REL_NE = 2'd3
  } pix_rel_e;
endpackage

// File: rtl/pix_lane_arith.sv
module pix_lane_arith #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  output logic [DATA_W-1:0] y
);
  localparam int unsigned NLANE = DATA_W / LANE_W;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb;
    assign la = a[g*LANE_W +: LANE_W];
    assign lb = b[g*LANE_W +: LANE_W];
    assign y[g*LANE_W +: LANE_W] = sub ? (lb - la) : (lb + la);
  end
endmodule

// File: rtl/pix_lane_cmp.sv
module pix_lane_cmp #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned NLANE = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [NLANE-1:0]  gt_mask,
  output logic [NLANE-1:0]  eq_mask
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign gt_mask[g] = a[g*LANE_W +: LANE_W] >  b[g*LANE_W +: LANE_W];
    assign eq_mask[g] = a[g*LANE_W +: LANE_W] == b[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/pix_byte_layout.sv
module pix_byte_layout #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTE  = 4,
  parameter int unsigned EXP_SH = 4,
  localparam int unsigned IN_W  = BYTE_W * NBYTE,
  localparam int unsigned OUT_W = 2 * IN_W,
  localparam int unsigned WIDE_W = 2 * BYTE_W
) (
  input  logic [IN_W-1:0]  a_lo,
  input  logic [IN_W-1:0]  b_lo,
  output logic [OUT_W-1:0] merged,
  output logic [OUT_W-1:0] expanded
);
  localparam int unsigned PAD_W = WIDE_W - BYTE_W - EXP_SH;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    // A byte goes in the upper half of each pair, B byte in the lower
    assign merged[(2*i+1)*BYTE_W +: BYTE_W] = a_lo[i*BYTE_W +: BYTE_W];
    assign merged[(2*i)*BYTE_W   +: BYTE_W] = b_lo[i*BYTE_W +: BYTE_W];
    assign expanded[i*WIDE_W +: WIDE_W] =
      {{PAD_W{1'b0}}, a_lo[i*BYTE_W +: BYTE_W], {EXP_SH{1'b0}}};
  end
endmodule

// File: rtl/pix_simd_unit.sv
module pix_simd_unit
  import pix_pkg::*;
#(
  parameter int unsigned D_W = pix_pkg::DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic [OP_W-1:0]      op,
  input  logic [D_W-1:0]       opa,
  input  logic [D_W-1:0]       opb,
  output logic                 res_vld,
  output logic [D_W-1:0]       res
);
  localparam int unsigned HALF_W = D_W / 2;
  localparam int unsigned N16    = D_W / 16;
  localparam int unsigned N32    = D_W / 32;

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [D_W-1:0] sum16, sum32, dif16, dif32, merged, expanded;
  logic [N16-1:0] gt16, eq16;
  logic [N32-1:0] gt32, eq32;

  pix_lane_arith #(.DATA_W(D_W), .LANE_W(16)) u_add16 (.a(opa), .b(opb), .sub(1'b0), .y(sum16));
  pix_lane_arith #(.DATA_W(D_W), .LANE_W(32)) u_add32 (.a(opa), .b(opb), .sub(1'b0), .y(sum32));
  pix_lane_arith #(.DATA_W(D_W), .LANE_W(16)) u_sub16 (.a(opa), .b(opb), .sub(1'b1), .y(dif16));
  pix_lane_arith #(.DATA_W(D_W), .LANE_W(32)) u_sub32 (.a(opa), .b(opb), .sub(1'b1), .y(dif32));

  pix_lane_cmp #(.DATA_W(D_W), .LANE_W(16)) u_cmp16 (.a(opa), .b(opb), .gt_mask(gt16), .eq_mask(eq16));
  pix_lane_cmp #(.DATA_W(D_W), .LANE_W(32)) u_cmp32 (.a(opa), .b(opb), .gt_mask(gt32), .eq_mask(eq32));

  pix_byte_layout #(.BYTE_W(8), .NBYTE(HALF_W/8), .EXP_SH(4)) u_layout (
    .a_lo    (opa[HALF_W-1:0]),
    .b_lo    (opb[HALF_W-1:0]),
    .merged  (merged),
    .expanded(expanded)
  );

  // compare mask selection
  pix_rel_e       rel;
  logic [N16-1:0] mask16;
  logic [N32-1:0] mask32;
  always_comb begin
    rel = pix_rel_e'(op[2:1]);
    unique case (rel)
      REL_GT: begin mask16 = gt16;          mask32 = gt32;          end
      REL_EQ: begin mask16 = eq16;          mask32 = eq32;          end
      REL_LE: begin mask16 = ~gt16;         mask32 = ~gt32;         end
      default: begin mask16 = ~eq16;        mask32 = ~eq32;         end
    endcase
  end

  // next-state result
  logic [D_W-1:0] res_d;
  always_comb begin
    res_d = '0;
    case (op)
      OP_MERGE:  res_d = merged;
      OP_EXPAND: res_d = expanded;
      OP_ADD16:  res_d = sum16;
      OP_ADD32:  res_d = sum32;
      OP_SUB16:  res_d = dif16;
      OP_SUB32:  res_d = dif32;
      OP_ADD16N: res_d[HALF_W-1:0] = sum16[HALF_W-1:0];
      OP_ADD32N: res_d[HALF_W-1:0] = sum32[HALF_W-1:0];
      OP_SUB16N: res_d[HALF_W-1:0] = dif16[HALF_W-1:0];
      OP_SUB32N: res_d[HALF_W-1:0] = dif32[HALF_W-1:0];
      OP_GT16, OP_EQ16, OP_LE16, OP_NE16: res_d[N16-1:0] = mask16;
      OP_GT32, OP_EQ32, OP_LE32, OP_NE32: res_d[N32-1:0] = mask32;
      default:   res_d = '0;
    endcase
  end

  // result register with explicit enable
  logic           vld_q;
  logic [D_W-1:0] res_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) res_q <= res_d;
    end
  end

  assign res_vld = vld_q;
  assign res     = res_q;
endmodule

// File: rtl/pix_simd_unit_chk.sv
module pix_simd_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [4:0]  op,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic        res_vld,
  input logic [63:0] res
);
  // R1
  rst_state_chk: assert property (@(posedge clk) !rst_n |=> (!res_vld && res == 64'd0));

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> res_vld);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_vld && !$isunknown(res)) |=> (!res_vld && $stable(res)));

  // R3
  merge_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op == 5'd0) |=> (res[7:0] == $past(opb[7:0]) && res[63:56] == $past(opa[31:24])));

  // R5
  add16_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op == 5'd2) |=> res[15:0] == 16'($past(opb[15:0]) + $past(opa[15:0])));

  // R7
  narrow_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op >= 5'd6 && op <= 5'd9) |=> res[63:32] == 32'd0);

  // R9
  mask_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op[4:3] == 2'b10) |=> res[63:4] == 60'd0);

  // R10
  undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (op[4:3] == 2'b11 || (op >= 5'd10 && op <= 5'd15))) |=> res == 64'd0);
endmodule

bind pix_simd_unit pix_simd_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op),
  .opa(opa), .opb(opb), .res_vld(res_vld), .res(res)
);

// File: tb/pix_simd_unit_tb.sv
module pix_simd_unit_tb;
  logic        clk;
  logic        rst_n;
  logic        in_vld;
  logic [4:0]  op;
  logic [63:0] opa, opb;
  logic        res_vld;
  logic [63:0] res;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  pix_simd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op(op),
    .opa(opa), .opb(opb), .res_vld(res_vld), .res(res)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // independent reference model built from the requirements
  function automatic logic [63:0] model(logic [4:0] o, logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    logic [15:0] x16;
    logic [31:0] x32;
    int          nl;
    bit          rel;
    r = '0;
    if (o == 5'd0) begin
      for (int i = 0; i < 4; i++) begin
        r[i*16 +: 8]     = b[i*8 +: 8];
        r[i*16 + 8 +: 8] = a[i*8 +: 8];
      end
    end else if (o == 5'd1) begin
      for (int i = 0; i < 4; i++) r[i*16 +: 16] = {4'h0, a[i*8 +: 8], 4'h0};
    end else if (o >= 5'd2 && o <= 5'd9) begin
      bit sub, wide, narrow;
      sub    = (o == 5'd4 || o == 5'd5 || o == 5'd8 || o == 5'd9);
      wide   = (o == 5'd3 || o == 5'd5 || o == 5'd7 || o == 5'd9);
      narrow = (o >= 5'd6);
      if (wide) begin
        nl = narrow ? 1 : 2;
        for (int i = 0; i < nl; i++) begin
          x32 = sub ? b[i*32 +: 32] - a[i*32 +: 32] : b[i*32 +: 32] + a[i*32 +: 32];
          r[i*32 +: 32] = x32;
        end
      end else begin
        nl = narrow ? 2 : 4;
        for (int i = 0; i < nl; i++) begin
          x16 = sub ? b[i*16 +: 16] - a[i*16 +: 16] : b[i*16 +: 16] + a[i*16 +: 16];
          r[i*16 +: 16] = x16;
        end
      end
    end else if (o >= 5'd16 && o <= 5'd23) begin
      nl = o[0] ? 2 : 4;
      for (int i = 0; i < nl; i++) begin
        logic [31:0] la, lb;
        la = o[0] ? a[i*32 +: 32] : {16'h0, a[i*16 +: 16]};
        lb = o[0] ? b[i*32 +: 32] : {16'h0, b[i*16 +: 16]};
        case (o[2:1])
          2'd0: rel = la >  lb;
          2'd1: rel = la == lb;
          2'd2: rel = la <= lb;
          default: rel = la != lb;
        endcase
        r[i] = rel;
      end
    end
    return r;
  endfunction

  // issue one strobe, sample the result one edge later
  task automatic run_op(string req, logic [4:0] o, logic [63:0] a, logic [63:0] b);
    @(negedge clk);
    in_vld = 1'b1; op = o; opa = a; opb = b;
    @(negedge clk);
    in_vld = 1'b0;
    check(req, res, model(o, a, b));
    check("R2 valid", {63'd0, res_vld}, 64'd1);
  endtask

  task automatic t_reset;
    check("R1 res", res, 64'd0);
    check("R1 vld", {63'd0, res_vld}, 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    run_op("R5 add16", 5'd2, 64'h0001_0002_0003_0004, 64'h1000_2000_3000_4000);
    keep = res;
    @(negedge clk);
    opa = 64'hFFFF_FFFF_FFFF_FFFF; op = 5'd3;
    @(negedge clk);
    check("R2 hold", res, keep);
    check("R2 idle vld", {63'd0, res_vld}, 64'd0);
  endtask

  task automatic t_merge;
    run_op("R3 merge", 5'd0, 64'hDEAD_BEEF_A3A2_A1A0, 64'hCAFE_F00D_B3B2_B1B0);
    check("R3 merge literal", res, 64'hA3B3_A2B2_A1B1_A0B0);
    run_op("R3 merge b", 5'd0, 64'h0000_0000_0102_0304, 64'hFFFF_FFFF_F0E0_D0C0);
  endtask

  task automatic t_expand;
    run_op("R4 expand", 5'd1, 64'h1234_5678_FF80_017F, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R4 expand literal", res, 64'h0FF0_0800_0010_07F0);
    run_op("R4 expand zero", 5'd1, 64'hFFFF_FFFF_0000_0000, 64'h1234_5678_9ABC_DEF0);
  endtask

  task automatic t_addsub;
    run_op("R5 add16 carry", 5'd2, 64'h0001_FFFF_0001_8000, 64'hFFFF_0001_7FFF_8000);
    check("R5 add16 literal", res, 64'h0000_0000_8000_0000);
    run_op("R5 add32 carry", 5'd3, 64'h0000_0001_8000_0001, 64'hFFFF_FFFF_7FFF_FFFF);
    run_op("R6 sub16 borrow", 5'd4, 64'h0001_0000_0005_0002, 64'h0000_0001_0003_0010);
    check("R6 sub16 literal", res, 64'hFFFF_0001_FFFE_000E);
    run_op("R6 sub32 borrow", 5'd5, 64'h0000_0001_0000_0002, 64'h0000_0000_0001_0000);
  endtask

  task automatic t_narrow;
    run_op("R7 add16n", 5'd6, 64'hFFFF_FFFF_FFFF_0001, 64'h1111_1111_0001_FFFF);
    run_op("R7 add32n", 5'd7, 64'h7777_7777_0000_0001, 64'h8888_8888_FFFF_FFFF);
    run_op("R7 sub16n", 5'd8, 64'h0101_0101_0003_0001, 64'h0202_0202_0001_0000);
    run_op("R7 sub32n", 5'd9, 64'hAAAA_AAAA_0000_0001, 64'h5555_5555_0000_0000);
  endtask

  task automatic t_compare;
    logic [63:0] a16, b16, a32, b32;
    // lanes: greater, equal, less, unsigned-large vs small
    a16 = 64'h8000_0005_0005_0009;
    b16 = 64'h0001_0007_0005_0003;
    a32 = 64'h8000_0000_0000_1234;
    b32 = 64'h0000_0001_0000_1234;
    for (int k = 16; k <= 23; k++) begin
      if (k[0]) run_op("R8 R9 cmp32", 5'(k), a32, b32);
      else      run_op("R8 R9 cmp16", 5'(k), a16, b16);
    end
    run_op("R8 gt16", 5'd16, a16, b16);
    check("R9 gt16 literal", res, 64'h0000_0000_0000_0009);
    run_op("R8 le32", 5'd21, a32, b32);
    check("R9 le32 literal", res, 64'h0000_0000_0000_0001);
  endtask

  task automatic t_undef;
    run_op("R10 undef12", 5'd12, 64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F);
    check("R10 zero", res, 64'd0);
    run_op("R10 undef31", 5'd31, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
  endtask

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; op = '0; opa = '0; opb = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_merge;
    t_expand;
    t_addsub;
    t_narrow;
    t_compare;
    t_undef;
    t_hold;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule